// File: doc/BRIEF.md
# Serial Key-Unlocked Register Access Sequencer

This block watches an asynchronous SRAM-style bus: an active-low chip select, an active-low output enable, an active-low write enable and the lowest data bit. It opens a hidden 64-bit register to that bus without any extra pins. It samples the controls into the clock domain and finds each bus cycle. It treats the bit carried on every write cycle as one bit of a secret key. Until the whole key has been written in order, every access still goes to the memory array as usual. Once the key is complete, the next cycles move the hidden register one bit at a time on the data bit, and the memory array is blocked for those cycles.

The direction of each transfer cycle follows the controls of that cycle, so reads and writes may be mixed. A read cycle shifts out one bit of a copy of the register taken at unlock. A write cycle replaces that bit with the bit on the bus. If any transfer cycle was a write, the assembled word is handed back to the register with one load strobe when the transfer ends. Any read while the key is being entered starts the key over. A wrong key bit locks out recognition until the next read.

Top module: `keyUnlockSeq`

## Requirements
- R1: After reset `memEnable` is 1, `dq0Oe` is 0 and `regLoad` is 0.
- R2: A bus cycle is one low interval of `ceN`. It is a write cycle if `weN` was low at some time during it, and otherwise a read cycle. On each write cycle the data bit last seen with both `ceN` and `weN` low is compared with key bit `KEY[ptr]`, where the pointer starts at bit 0 (least significant bit first). A match advances the pointer. When bit `KEY_W-1` matches, the block enters transfer.
- R3: A mismatching key bit freezes recognition. Later write cycles are ignored, even a complete correct key, until a read cycle occurs.
- R4: Any read cycle before the key is complete returns the pointer to bit 0, so a key split by a read does not unlock.
- R5: `memEnable` stays 1 through all key-writing cycles. It drops to 0 only after the cycle carrying the last key bit ends, within 6 clocks of `ceN` rising.
- R6: During transfer, a read cycle with `oeN` low drives `dq0Oe`=1 and `dq0Out` = bit k of `regRdData` as sampled at unlock, for the k-th transfer cycle (k from 0).
- R7: After exactly `REG_W` transfer cycles the block returns to key hunting with the pointer at bit 0 and `memEnable`=1. A correct key may follow at once, without a read in between.
- R8: If at least one transfer cycle was a write, `regLoad` pulses once for one clock at the end of the transfer. In the `regWrData` word, bit k is the bit written in cycle k for write cycles and the snapshot bit k for read cycles. A transfer made only of reads produces no pulse.
- R9: Bus activity with `ceN` high changes neither the key pointer nor the transfer count.
- R10: A read during transfer does not end the transfer early, and `dq0Oe` is never 1 outside transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Bus chip select, active low, asynchronous |
| oeN | input | 1 | Bus output enable, active low, asynchronous |
| weN | input | 1 | Bus write enable, active low, asynchronous |
| dq0In | input | 1 | Bus data bit 0 as driven by the host |
| regRdData | input | REG_W | Current value of the hidden register |
| memEnable | output | 1 | 1 lets the memory array answer bus cycles |
| dq0Out | output | 1 | Data bit 0 value driven during transfer reads |
| dq0Oe | output | 1 | Output enable for `dq0Out` |
| regLoad | output | 1 | One-clock strobe to load `regWrData` into the register |
| regWrData | output | REG_W | Word assembled during transfer |

## Verification
Two functions can land on the same cycle boundary. The first is the cycle that ends a transfer, which also restarts key hunting. The second is the parallel load, which has to carry both snapshot bits and freshly written bits. The bench forces the first by writing a full key right after a transfer, with no read between. It forces the second with a transfer of half reads followed by half writes. The expected word is built arithmetically from the old register value and the written bits. Reset of the key pointer by a read is tested against a key split across a read, and freezing is tested with one flipped bit.

// File: rtl/keyUnlockPkg.sv
package keyUnlockPkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_FROZEN = 2'd1,
    ST_XFER   = 2'd2
  } seqState_t;

  typedef struct packed {
    logic ptrClr;
    logic ptrInc;
    logic snap;
    logic shiftEn;
    logic shiftIn;
    logic shiftWr;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/keySeqCtrl.sv
module keySeqCtrl
  import keyUnlockPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       weN,
  input  logic       dq0In,
  input  logic       keyBit,
  input  logic       ptrLast,
  input  logic       cntLast,
  output seqStrobe_t strb,
  output logic       memEnable,
  output logic       dq0Oe
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] syncPipe [SYNC_STAGES];
  logic ceS, oeS, weS, dqS, ceD;
  logic seenWe, wrBit, cycleEnd;
  seqState_t state, stateNxt;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[g] <= 4'b1110;
        else if (g == 0) syncPipe[g] <= {ceN, oeN, weN, dq0In};
        else syncPipe[g] <= syncPipe[g-1];
      end
    end
  endgenerate

  assign {ceS, oeS, weS, dqS} = syncPipe[SYNC_STAGES-1];
  assign cycleEnd = ceS && !ceD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceD    <= 1'b1;
      seenWe <= 1'b0;
      wrBit  <= 1'b0;
      state  <= ST_HUNT;
    end else begin
      ceD   <= ceS;
      state <= stateNxt;
      if (!ceS && !weS) begin
        seenWe <= 1'b1;
        wrBit  <= dqS;
      end else if (cycleEnd) begin
        seenWe <= 1'b0;
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.shiftIn = wrBit;
    strb.shiftWr = seenWe;
    stateNxt     = state;
    if (cycleEnd) begin
      unique case (state)
        ST_HUNT: begin
          if (!seenWe) strb.ptrClr = 1'b1;
          else if (wrBit == keyBit) begin
            if (ptrLast) begin
              strb.ptrClr = 1'b1;
              strb.snap   = 1'b1;
              stateNxt    = ST_XFER;
            end else begin
              strb.ptrInc = 1'b1;
            end
          end else begin
            stateNxt = ST_FROZEN;
          end
        end
        ST_FROZEN: begin
          if (!seenWe) begin
            strb.ptrClr = 1'b1;
            stateNxt    = ST_HUNT;
          end
        end
        ST_XFER: begin
          strb.shiftEn = 1'b1;
          if (cntLast) begin
            strb.finish = 1'b1;
            strb.ptrClr = 1'b1;
            stateNxt    = ST_HUNT;
          end
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  assign memEnable = (state != ST_XFER);
  assign dq0Oe     = (state == ST_XFER) && !ceS && !oeS && weS && !seenWe;
endmodule

// File: rtl/keySeqData.sv
module keySeqData
  import keyUnlockPkg::*;
#(
  parameter int          KEY_W = 64,
  parameter int          REG_W = 64,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [REG_W-1:0] regRdData,
  output logic             keyBit,
  output logic             ptrLast,
  output logic             cntLast,
  output logic             shadowBit,
  output logic             regLoad,
  output logic [REG_W-1:0] regWrData
);
  localparam int PTR_W = $clog2(KEY_W);
  localparam int CNT_W = $clog2(REG_W);

  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] shadow;
  logic             anyWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      cnt     <= '0;
      shadow  <= '0;
      anyWr   <= 1'b0;
      regLoad <= 1'b0;
    end else begin
      regLoad <= strb.finish && (anyWr || strb.shiftWr);
      if (strb.ptrClr) ptr <= '0;
      else if (strb.ptrInc) ptr <= ptr + 1'b1;
      if (strb.snap) begin
        shadow <= regRdData;
        cnt    <= '0;
        anyWr  <= 1'b0;
      end else if (strb.shiftEn) begin
        shadow <= {strb.shiftWr ? strb.shiftIn : shadow[0], shadow[REG_W-1:1]};
        cnt    <= cnt + 1'b1;
        anyWr  <= anyWr || strb.shiftWr;
      end
    end
  end

  assign keyBit    = KEY[ptr];
  assign ptrLast   = (ptr == PTR_W'(KEY_W - 1));
  assign cntLast   = (cnt == CNT_W'(REG_W - 1));
  assign shadowBit = shadow[0];
  assign regWrData = shadow;
endmodule

// File: rtl/keyUnlockSeq.sv
module keyUnlockSeq
  import keyUnlockPkg::*;
#(
  parameter int          KEY_W = 64,
  parameter int          REG_W = 64,
  parameter logic [KEY_W-1:0] KEY = 64'hD1E2_5A3C_0F96_7B48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             oeN,
  input  logic             weN,
  input  logic             dq0In,
  input  logic [REG_W-1:0] regRdData,
  output logic             memEnable,
  output logic             dq0Out,
  output logic             dq0Oe,
  output logic             regLoad,
  output logic [REG_W-1:0] regWrData
);
  seqStrobe_t strb;
  logic keyBit, ptrLast, cntLast, shadowBit;

  keySeqCtrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .dq0In(dq0In),
    .keyBit(keyBit), .ptrLast(ptrLast), .cntLast(cntLast),
    .strb(strb), .memEnable(memEnable), .dq0Oe(dq0Oe)
  );

  keySeqData #(.KEY_W(KEY_W), .REG_W(REG_W), .KEY(KEY)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .regRdData(regRdData),
    .keyBit(keyBit), .ptrLast(ptrLast), .cntLast(cntLast),
    .shadowBit(shadowBit), .regLoad(regLoad), .regWrData(regWrData)
  );

  assign dq0Out = dq0Oe ? shadowBit : 1'b0;
endmodule

// File: rtl/keyUnlockSeqChk.sv
module keyUnlockSeqChk (
  input logic clk,
  input logic rstN,
  input logic ceN,
  input logic memEnable,
  input logic dq0Oe,
  input logic regLoad
);
  a_r10_oe_only_xfer: assert property (@(posedge clk) disable iff (!rstN)
    dq0Oe |-> !memEnable);

  a_r8_load_single: assert property (@(posedge clk) disable iff (!rstN)
    regLoad |=> !regLoad);

  a_r8_load_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regLoad) |-> (memEnable && $past(ceN)));

  a_r5_unlock_after_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memEnable) |-> $past(ceN));

  a_r7_relock_after_cycle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memEnable) |-> $past(ceN));
endmodule

bind keyUnlockSeq keyUnlockSeqChk uChk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .memEnable(memEnable),
  .dq0Oe(dq0Oe), .regLoad(regLoad)
);

// File: tb/sim_keyUnlockSeq.sv
module sim_keyUnlockSeq;
  localparam logic [63:0] KEY = 64'hD1E2_5A3C_0F96_7B48;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, dq0In = 1'b0;
  logic [63:0] tkReg = 64'h0123_4567_89AB_CDEF;
  logic memEnable, dq0Out, dq0Oe, regLoad;
  logic [63:0] regWrData;
  int tests = 0, fails = 0, loads = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyUnlockSeq u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .dq0In(dq0In),
    .regRdData(tkReg), .memEnable(memEnable), .dq0Out(dq0Out), .dq0Oe(dq0Oe),
    .regLoad(regLoad), .regWrData(regWrData)
  );

  always @(posedge clk) if (regLoad) begin
    tkReg <= regWrData;
    loads <= loads + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCyc(input logic b);
    @(negedge clk); ceN = 0;
    @(negedge clk); weN = 0; dq0In = b;
    repeat (4) @(negedge clk);
    weN = 1;
    @(negedge clk); ceN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rdCyc(output logic bv, output logic oev);
    @(negedge clk); ceN = 0; oeN = 0;
    repeat (5) @(negedge clk);
    bv = dq0Out; oev = dq0Oe;
    ceN = 1; oeN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic foreign();
    @(negedge clk); weN = 0; oeN = 0; dq0In = ~dq0In;
    repeat (4) @(negedge clk);
    weN = 1; oeN = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendKey(input int from, input int to);
    for (int i = from; i < to; i++) wrCyc(KEY[i]);
  endtask

  task automatic readAll(output logic [63:0] got, output int oeCnt);
    logic b, o;
    oeCnt = 0;
    for (int k = 0; k < 64; k++) begin
      rdCyc(b, o);
      got[k] = b;
      if (o) oeCnt++;
    end
  endtask

  task automatic writeAll(input logic [63:0] v);
    for (int k = 0; k < 64; k++) wrCyc(v[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic b, o;
    logic [63:0] got, old, nw, pats [4];
    int oeCnt, l0;
    pats[0] = 64'hFFFF_0000_AAAA_5555;
    pats[1] = 64'h0000_0000_0000_0001;
    pats[2] = 64'h8000_0000_0000_0000;
    pats[3] = 64'hFEDC_BA98_7654_3210;
    repeat (3) @(negedge clk);
    chk(memEnable === 1'b1, "R1 memEnable", memEnable, 1);
    chk(dq0Oe === 1'b0, "R1 dq0Oe", dq0Oe, 0);
    chk(regLoad === 1'b0, "R1 regLoad", regLoad, 0);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R10: read outside transfer does not drive
    rdCyc(b, o);
    chk(o === 1'b0, "R10 no drive when locked", o, 0);

    // R5/R2: key entry keeps memory enabled until last bit
    sendKey(0, 63);
    chk(memEnable === 1'b1, "R5 mem enabled during key", memEnable, 1);
    sendKey(63, 64);
    chk(memEnable === 1'b0, "R2 unlock after full key", memEnable, 0);

    // R6: read transfer of snapshot, R10 reads do not abort
    old = tkReg; l0 = loads;
    readAll(got, oeCnt);
    chk(got === old, "R6 read data", got, old);
    chk(oeCnt == 64, "R6 dq0Oe during reads", oeCnt, 64);
    chk(memEnable === 1'b1, "R7 relock after 64", memEnable, 1);
    chk(loads == l0, "R8 no load on read-only", loads, l0);

    // R8/R7/R6 sweep: write then read back; key right after transfer end
    for (int p = 0; p < 4; p++) begin
      sendKey(0, 64);
      chk(memEnable === 1'b0, "R7 unlock without read", memEnable, 0);
      l0 = loads;
      writeAll(pats[p]);
      chk(loads == l0 + 1, "R8 single load", loads, l0 + 1);
      chk(tkReg === pats[p], "R8 loaded word", tkReg, pats[p]);
      sendKey(0, 64);
      readAll(got, oeCnt);
      chk(got === pats[p], "R6 read back", got, pats[p]);
    end

    // R8 mixed transfer: 32 reads then 32 writes
    old = tkReg; nw = 64'h1357_9BDF_2468_ACE0;
    sendKey(0, 64);
    for (int k = 0; k < 32; k++) begin
      rdCyc(b, o);
      chk(b === old[k], "R6 mixed read bit", b, old[k]);
    end
    for (int k = 0; k < 32; k++) wrCyc(nw[k]);
    chk(tkReg === {nw[31:0], old[31:0]}, "R8 mixed word", tkReg, {nw[31:0], old[31:0]});

    // R3: a wrong bit freezes; a later correct key is ignored until a read
    rdCyc(b, o);
    sendKey(0, 5);
    wrCyc(~KEY[5]);
    sendKey(0, 64);
    chk(memEnable === 1'b1, "R3 frozen ignores key", memEnable, 1);
    rdCyc(b, o);
    sendKey(0, 64);
    chk(memEnable === 1'b0, "R3 read clears freeze", memEnable, 0);
    readAll(got, oeCnt);

    // R4: a read in the middle restarts the key
    sendKey(0, 30);
    rdCyc(b, o);
    sendKey(30, 64);
    chk(memEnable === 1'b1, "R4 split key rejected", memEnable, 1);
    rdCyc(b, o);
    sendKey(0, 64);
    chk(memEnable === 1'b0, "R4 full key after read", memEnable, 0);
    readAll(got, oeCnt);

    // R9: foreign bus activity with chip select high
    sendKey(0, 20);
    for (int i = 0; i < 10; i++) foreign();
    sendKey(20, 64);
    chk(memEnable === 1'b0, "R9 key survives foreign", memEnable, 0);
    old = tkReg;
    for (int k = 0; k < 63; k++) begin
      rdCyc(b, o);
      if (k == 10) for (int i = 0; i < 5; i++) foreign();
    end
    chk(memEnable === 1'b0, "R9 count unaffected", memEnable, 0);
    rdCyc(b, o);
    chk(b === old[63], "R9 last bit", b, old[63]);
    chk(memEnable === 1'b1, "R9 transfer ends", memEnable, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule